// File: doc/BRIEF.md
# Byte-Writable Pipelined SRAM Datapath

This block is the storage and data path of a synchronous static RAM with 32-bit words and individually writable bytes. An address sequencer outside the block supplies the word address and a flag saying whether the device is selected on this clock edge. The block uses a global write strobe, a byte-write strobe and one select per byte lane to decide which lanes, if any, are written on that edge. It registers read data one edge after the address, so the result appears in the following cycle.

Three-state pins are modelled by a read data bus and a drive flag. The flag follows the output enable combinationally, but it stays low after a write or a deselected edge. It is also held low for the first read cycle that comes straight after a deselected edge, whatever the output enable is doing. A build option sets whether the read bus holds its last value or reads as zero while the flag is low. The word count and data width are parameters. Set the address width to 16 for the full 64K-word array.

Top module: `bw_sram_dp`

## Requirements
- R1: On a selected edge with `gw_n` low, every byte lane of the addressed word takes `wdata`, whatever the values of `bwe_n` and `bsel_n`.
- R2: On a selected edge with `gw_n` high and `bwe_n` low, lane n (bits 8n+7 down to 8n) of the addressed word is written exactly when `bsel_n[n]` is low. The other lanes keep their contents.
- R3: On a selected edge with `gw_n` and `bwe_n` both high, the cycle is a read. No lane is modified, whatever the value of `bsel_n`.
- R4: After a read edge, `rdata` shows the word stored at the address sampled on that edge. It holds that value until the next read edge.
- R5: `drive` is high only while `oe_n` is low. It responds to `oe_n` within the same cycle, with no clock edge in between.
- R6: When a read edge directly follows a deselected edge (`sel` low), `drive` stays low for that cycle even with `oe_n` low. A read edge that follows another read edge does not mask `drive`.
- R7: After any selected edge with `gw_n` or `bwe_n` low, `drive` is low for the following cycle.
- R8: An edge with `sel` low writes nothing, even with `gw_n` low, and `drive` is low in the following cycle.
- R9: While `rst_n` is low and directly after it is released, `drive` is low and `rdata` is zero.
- R10: With `OUT_GATE` = 1, `rdata` reads zero in every cycle in which `drive` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all synchronous inputs sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the control and read registers |
| addr | input | ADDR_W | Word address from the sequencer |
| sel | input | 1 | Device selected on this edge |
| gw_n | input | 1 | Global write, active low; writes all lanes |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | DATA_W/8 | Per-lane write selects, active low |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data of the address sampled on the last read edge |
| drive | output | 1 | High when the read bus would be driven onto the pins |

## Verification
The bench builds the block with `ADDR_W` = 4, `DATA_W` = 32 and `OUT_GATE` = 1. With only sixteen words, the random phase keeps landing global writes, partial byte writes and reads on the same locations, so lane merging and the ordering of write and read are exercised many times over. The gated variant makes the bus value testable in every cycle, including the masked first read after a deselect and the cycles right after writes.

// File: rtl/bw_sram_dp_pkg.sv
package bw_sram_dp_pkg;
   typedef enum logic [1:0] {
      CYC_IDLE  = 2'd0,
      CYC_WRITE = 2'd1,
      CYC_READ  = 2'd2
   } cyc_e;

   localparam int LANE_W = 8;
endpackage

// File: rtl/bw_sram_dp_ctrl.sv
module bw_sram_dp_ctrl
   import bw_sram_dp_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             sel,
   input  logic             gw_n,
   input  logic             bwe_n,
   input  logic [LANES-1:0] bsel_n,
   output cyc_e             cyc,
   output logic [LANES-1:0] lane_we
);
   always_comb begin
      cyc     = CYC_IDLE;
      lane_we = '0;
      if (sel) begin
         if (!gw_n) begin
            cyc     = CYC_WRITE;
            lane_we = '1;
         end else if (!bwe_n) begin
            cyc     = CYC_WRITE;
            lane_we = ~bsel_n;
         end else begin
            cyc     = CYC_READ;
         end
      end
   end
endmodule

// File: rtl/bw_sram_dp_bank.sv
module bw_sram_dp_bank
   import bw_sram_dp_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES-1:0]        lane_we,
   input  logic                    rd_en,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rd_word
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar n = 0; n < LANES; n++) begin : g_lane
      logic [LANE_W-1:0] store [DEPTH];
      logic [LANE_W-1:0] rd_q;

      always_ff @(posedge clk) begin
         if (lane_we[n]) store[addr] <= wdata[n*LANE_W +: LANE_W];
      end

      always_ff @(posedge clk) begin
         if (!rst_n)     rd_q <= '0;
         else if (rd_en) rd_q <= store[addr];
      end

      assign rd_word[n*LANE_W +: LANE_W] = rd_q;
   end
endmodule

// File: rtl/bw_sram_dp_out.sv
module bw_sram_dp_out
   import bw_sram_dp_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter bit OUT_GATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cyc_e              cyc,
   input  logic              oe_n,
   input  logic [DATA_W-1:0] rd_word,
   output logic [DATA_W-1:0] rdata,
   output logic              drive
);
   logic valid_q;
   logic mask_q;
   logic was_desel_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q     <= 1'b0;
         mask_q      <= 1'b0;
         was_desel_q <= 1'b1;
      end else begin
         valid_q     <= (cyc == CYC_READ);
         mask_q      <= (cyc == CYC_READ) && was_desel_q;
         was_desel_q <= (cyc == CYC_IDLE);
      end
   end

   assign drive = valid_q & ~mask_q & ~oe_n;

   if (OUT_GATE) begin : g_gated
      assign rdata = drive ? rd_word : '0;
   end else begin : g_hold
      assign rdata = rd_word;
   end
endmodule

// File: rtl/bw_sram_dp.sv
module bw_sram_dp
   import bw_sram_dp_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter bit OUT_GATE = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [ADDR_W-1:0]      addr,
   input  logic                   sel,
   input  logic                   gw_n,
   input  logic                   bwe_n,
   input  logic [DATA_W/8-1:0]    bsel_n,
   input  logic                   oe_n,
   input  logic [DATA_W-1:0]      wdata,
   output logic [DATA_W-1:0]      rdata,
   output logic                   drive
);
   localparam int LANES = DATA_W / LANE_W;

   if (DATA_W % LANE_W != 0 || DATA_W < LANE_W) begin : g_bad_width
      $error("bw_sram_dp: DATA_W must be a positive multiple of 8");
   end
   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
      $error("bw_sram_dp: ADDR_W must lie in 1..16");
   end

   cyc_e             cyc;
   logic [LANES-1:0] lane_we;
   logic [DATA_W-1:0] rd_word;

   bw_sram_dp_ctrl #(.LANES(LANES)) u_ctrl (
      .sel    (sel),
      .gw_n   (gw_n),
      .bwe_n  (bwe_n),
      .bsel_n (bsel_n),
      .cyc    (cyc),
      .lane_we(lane_we)
   );

   bw_sram_dp_bank #(.ADDR_W(ADDR_W), .LANES(LANES)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr   (addr),
      .lane_we(lane_we),
      .rd_en  (cyc == CYC_READ),
      .wdata  (wdata),
      .rd_word(rd_word)
   );

   bw_sram_dp_out #(.DATA_W(DATA_W), .OUT_GATE(OUT_GATE)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .cyc    (cyc),
      .oe_n   (oe_n),
      .rd_word(rd_word),
      .rdata  (rdata),
      .drive  (drive)
   );
endmodule

// File: rtl/bw_sram_dp_chk.sv
module bw_sram_dp_chk #(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter bit OUT_GATE = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                sel,
   input logic                gw_n,
   input logic                bwe_n,
   input logic                oe_n,
   input logic [DATA_W-1:0]   rdata,
   input logic                drive
);
   AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      sel && (!gw_n || !bwe_n) |=> !drive); // R7

   AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> !drive); // R8

   AST_FIRST_READ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      sel && gw_n && bwe_n && !$past(sel) |=> !drive); // R6

   AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !drive); // R5

   AST_GATED_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      (OUT_GATE && !drive) |-> (rdata == '0)); // R10

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> !drive); // R9
endmodule

bind bw_sram_dp bw_sram_dp_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OUT_GATE(OUT_GATE)
) u_chk (
   .clk  (clk),
   .rst_n(rst_n),
   .sel  (sel),
   .gw_n (gw_n),
   .bwe_n(bwe_n),
   .oe_n (oe_n),
   .rdata(rdata),
   .drive(drive)
);

// File: tb/bw_sram_dp_tb.sv
`timescale 1ns/1ps
module bw_sram_dp_tb;
   localparam int AW = 4;
   localparam int DW = 32;
   localparam int NW = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] addr;
   logic          sel, gw_n, bwe_n, oe_n;
   logic [3:0]    bsel_n;
   logic [DW-1:0] wdata;
   logic [DW-1:0] rdata;
   logic          drive;

   always #2 clk = ~clk;

   bw_sram_dp #(.ADDR_W(AW), .DATA_W(DW), .OUT_GATE(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .sel(sel), .gw_n(gw_n),
      .bwe_n(bwe_n), .bsel_n(bsel_n), .oe_n(oe_n), .wdata(wdata),
      .rdata(rdata), .drive(drive)
   );

   int vectors = 0;
   int errors  = 0;
   bit done    = 0;

   logic [DW-1:0] ref_mem [NW];
   logic [DW-1:0] m_rd    = '0;
   bit            m_valid = 0;
   bit            m_mask  = 0;
   bit            m_desel = 1;
   int            m_kind  = 0; // 0 desel, 1 write, 2 read

   task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_outputs(string tag);
      bit            exp_drv;
      string         dtag;
      exp_drv = m_valid && !m_mask && !oe_n;
      if (m_mask)           dtag = "R6";
      else if (m_kind == 1) dtag = "R7";
      else if (m_kind == 0) dtag = "R8";
      else if (oe_n)        dtag = "R5";
      else                  dtag = "R4";
      chk(dtag, {31'd0, drive}, {31'd0, exp_drv});
      chk(exp_drv ? tag : "R10", rdata, exp_drv ? m_rd : '0);
   endtask

   task automatic step(bit s, bit g, bit b, logic [3:0] bs, bit oe,
                       logic [AW-1:0] a, logic [DW-1:0] d, string tag);
      sel = s; gw_n = g; bwe_n = b; bsel_n = bs; oe_n = oe; addr = a; wdata = d;
      @(posedge clk);
      if (!s) begin
         m_valid = 0; m_desel = 1; m_kind = 0;
      end else if (!g) begin
         ref_mem[a] = d; m_valid = 0; m_desel = 0; m_kind = 1;
      end else if (!b) begin
         for (int n = 0; n < 4; n++)
            if (!bs[n]) ref_mem[a][n*8 +: 8] = d[n*8 +: 8];
         m_valid = 0; m_desel = 0; m_kind = 1;
      end else begin
         m_rd = ref_mem[a]; m_valid = 1; m_mask = m_desel; m_desel = 0; m_kind = 2;
      end
      if (m_kind != 2) m_mask = 0;
      #1;
      check_outputs(tag);
      @(negedge clk);
   endtask

   task automatic rd(logic [AW-1:0] a, string tag);
      step(1, 1, 1, 4'hF, 0, a, 32'hDEAD_BEEF, tag);
   endtask

   initial begin
      int unsigned cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            errors++;
            vectors++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
         end
      end
   end

   initial begin
      rst_n = 0; sel = 0; gw_n = 1; bwe_n = 1; bsel_n = 4'hF; oe_n = 0;
      addr = '0; wdata = '0;
      repeat (4) @(negedge clk);
      chk("R9", {31'd0, drive}, 32'd0);
      chk("R9", rdata, '0);
      rst_n = 1;
      @(negedge clk);
      chk("R9", {31'd0, drive}, 32'd0);
      chk("R9", rdata, '0);

      // R1: global writes, byte controls deliberately set to conflict
      for (int a = 0; a < NW; a++)
         step(1, 0, a[0], a[3:0], 0, a[AW-1:0], 32'h1357_9BDF ^ (a * 32'h0101_0101), "R1");
      for (int a = 0; a < NW; a++) rd(a[AW-1:0], "R1");

      // R2: partial byte writes with several lane patterns
      step(1, 1, 0, 4'b1110, 0, 4'd2, 32'hAAAA_AA11, "R2");
      step(1, 1, 0, 4'b0101, 0, 4'd3, 32'h22BB_33CC, "R2");
      step(1, 1, 0, 4'b1111, 0, 4'd4, 32'hFFFF_FFFF, "R2");
      step(1, 1, 0, 4'b0000, 0, 4'd5, 32'h0F0F_0F0F, "R2");
      step(1, 1, 0, 4'b0111, 0, 4'd6, 32'h9900_0000, "R2");
      for (int a = 2; a < 7; a++) rd(a[AW-1:0], "R2");

      // R3: read with lane selects low leaves storage untouched
      step(1, 1, 1, 4'b0000, 0, 4'd7, 32'h0000_0000, "R3");
      step(1, 1, 1, 4'b1010, 0, 4'd7, 32'h5555_5555, "R3");
      rd(4'd7, "R3");

      // R8 then R6: deselect with global write asserted, then two reads
      step(0, 0, 0, 4'h0, 0, 4'd8, 32'hBAD0_BAD0, "R8");
      rd(4'd8, "R6");
      rd(4'd8, "R8");
      step(0, 1, 1, 4'hF, 0, 4'd9, 32'h0, "R8");
      step(0, 1, 1, 4'hF, 0, 4'd9, 32'h0, "R8");
      rd(4'd9, "R6");
      rd(4'd10, "R4");

      // R4: back-to-back reads across addresses
      for (int a = NW - 1; a >= 0; a--) rd(a[AW-1:0], "R4");

      // R5: asynchronous output enable within one cycle
      rd(4'd1, "R5");
      oe_n = 1; #0.5;
      chk("R5", {31'd0, drive}, 32'd0);
      chk("R10", rdata, '0);
      oe_n = 0; #0.5;
      chk("R5", {31'd0, drive}, 32'd1);
      chk("R5", rdata, ref_mem[1]);
      @(negedge clk);
      step(1, 1, 1, 4'hF, 1, 4'd1, 32'h0, "R5");

      // R7: write right after read
      step(1, 0, 1, 4'hF, 0, 4'd1, 32'hC0FF_EE00, "R7");
      rd(4'd1, "R7");

      // mixed random traffic
      for (int i = 0; i < 400; i++) begin
         int unsigned r;
         r = $urandom;
         step(r[3:0] != 0, r[6:4] != 0, r[8:7] == 0, r[12:9], r[15:13] == 0,
              r[19:16], $urandom, "R4");
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule